// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block resolves one virtual address into a physical frame number after a translation miss. It takes a 48-bit virtual address and the physical base of the top-level table. It then reads one 8-byte entry per level from memory through a request/response port. When it finishes, it reports either a leaf translation ready for a TLB refill or a page fault that carries the virtual address. Each table node is a 4 KB page that holds 512 entries of 8 bytes, so each level is indexed by 9 bits of the virtual page number.

The walk starts with the level-4 table and continues through level 3, level 2 and level 1, always in that order. A present entry at level 2 with its size bit set ends the walk after three reads and describes a 2 MB page. An entry whose present bit is clear stops the walk at that level. Only one walk can be in flight at a time, and only one memory read can be outstanding.

Entry layout used throughout:

| Field | Bits |
|---|---|
| present | 0 |
| permission bits | 6:1 |
| page size | 7 |
| next-level base or frame number | 51:12 |

All other entry bits are ignored.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1 and `mem_req_valid`, `done_valid` and `fault_valid` are 0.
- R2: The first read of a walk goes to address `root_base[51:12]*4096 + vaddr[47:39]*8`. The low 12 bits of `root_base` are ignored.
- R3: Each later read goes to `entry[51:12]*4096 + idx*8`, where `entry` is the previous entry and `idx` is `vaddr[38:30]`, then `vaddr[29:21]`, then `vaddr[20:12]`. The reads follow this fixed order, and every read address is 8-byte aligned.
- R4: `mem_req_valid` is a one-cycle pulse, and the next read is issued only after `mem_rsp_valid` answers the previous one. `req_ready` is 0 from the cycle after a request is accepted until the result is reported.
- R5: When a fetched entry has bit 0 at 0, the walk issues no further reads. It pulses `fault_valid` for one cycle with `fault_vaddr` equal to the accepted virtual address, and `done_valid` stays low.
- R6: A present level-1 entry ends the walk after four reads. It pulses `done_valid` for one cycle with `done_pfn = entry[51:12]`, `done_huge = 0` and `done_perm = entry[6:1]`.
- R7: A present level-2 entry with bit 7 set ends the walk after three reads. It reports `done_pfn = {entry[51:21], vaddr[20:12]}`, `done_huge = 1` and `done_perm = entry[6:1]`.
- R8: Bit 7 of a level-4, level-3 or level-1 entry has no effect. The walk still takes four reads, and the result has `done_huge = 0`.
- R9: `req_valid` while a walk is busy has no effect on that walk, and neither does `mem_rsp_valid` while no read is outstanding. A response that arrives while idle produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, able to accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| root_base | input | 52 | Physical address of the top-level table |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done_valid | output | 1 | One-cycle translation result |
| done_pfn | output | 40 | Physical frame number in 4 KB units |
| done_huge | output | 1 | Result describes a 2 MB page |
| done_perm | output | 6 | Permission bits of the leaf entry |
| fault_valid | output | 1 | One-cycle page fault |
| fault_vaddr | output | 48 | Virtual address that faulted |

## Verification
Several situations are hard to reach from the ports. One is a fault at each of the four levels. Another is a response that arrives while no read is outstanding. A third is a new request held high during a busy walk. The bench creates each one by building a fresh table tree in a modelled memory for every walk. It sweeps the four indices over values that include 0 and 511, and it rotates the outcome between a 4 KB leaf, a 2 MB leaf, a fault at a chosen level, and size bits set on the upper and leaf levels. The memory latency also varies from walk to walk. Every so often the bench injects a stray response while the walker is idle, and on odd walks it keeps `req_valid` high with a different address until the result appears.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int VA_W     = 48;
    localparam int PA_W     = 52;
    localparam int PG_W     = 12;
    localparam int IDX_W    = 9;
    localparam int LVLS     = 4;
    localparam int ENT_W    = 64;
    localparam int PERM_W   = 6;
    localparam int PS_BIT   = 7;
    localparam int HUGE_LVL = 1;   // level-2 table, counted from 0 at the leaf

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ISSUE = 2'd1,
        WK_WAIT  = 2'd2
    } wk_state_e;
endpackage

// File: rtl/pt_idx_sel.sv
module pt_idx_sel #(
    parameter int VA_W  = 48,
    parameter int PG_W  = 12,
    parameter int IDX_W = 9,
    parameter int LVLS  = 4,
    parameter int PFN_W = 40,
    parameter int LVL_W = $clog2(LVLS)
) (
    input  logic [VA_W-1:0]        vaddr,
    input  logic [LVL_W-1:0]       lvl,
    input  logic [PFN_W-1:0]       base,
    output logic [PFN_W+PG_W-1:0]  addr
);
    localparam int ESH = PG_W - IDX_W;  // log2 of entry size in bytes

    logic [IDX_W-1:0] idx [LVLS];

    for (genvar g = 0; g < LVLS; g++) begin : g_idx
        assign idx[g] = vaddr[PG_W + g*IDX_W +: IDX_W];
    end

    assign addr = {base, idx[lvl], {ESH{1'b0}}};
endmodule

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
    parameter int VA_W     = 48,
    parameter int PG_W     = 12,
    parameter int IDX_W    = 9,
    parameter int LVLS     = 4,
    parameter int PFN_W    = 40,
    parameter int ENT_W    = 64,
    parameter int PERM_W   = 6,
    parameter int PS_BIT   = 7,
    parameter int HUGE_LVL = 1,
    parameter int LVL_W    = $clog2(LVLS)
) (
    input  logic [ENT_W-1:0]  entry,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [VA_W-1:0]   vaddr,
    output logic              present,
    output logic              leaf,
    output logic              huge,
    output logic [PFN_W-1:0]  next_base,
    output logic [PFN_W-1:0]  leaf_pfn,
    output logic [PERM_W-1:0] perm
);
    localparam int HSPAN = HUGE_LVL * IDX_W;

    assign present   = entry[0];
    assign perm      = entry[PERM_W:1];
    assign huge      = (lvl == LVL_W'(HUGE_LVL)) && entry[PS_BIT];
    assign leaf      = (lvl == '0) || huge;
    assign next_base = entry[PG_W +: PFN_W];

    always_comb begin
        leaf_pfn = next_base;
        if (huge) begin
            leaf_pfn[HSPAN-1:0] = vaddr[PG_W +: HSPAN];
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int P_VA_W  = VA_W,
    parameter int P_PA_W  = PA_W,
    parameter int P_PERM  = PERM_W,
    parameter int P_ENT_W = ENT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [P_VA_W-1:0]         req_vaddr,
    input  logic [P_PA_W-1:0]         root_base,
    output logic                      mem_req_valid,
    output logic [P_PA_W-1:0]         mem_req_addr,
    input  logic                      mem_rsp_valid,
    input  logic [P_ENT_W-1:0]        mem_rsp_data,
    output logic                      done_valid,
    output logic [P_PA_W-PG_W-1:0]    done_pfn,
    output logic                      done_huge,
    output logic [P_PERM-1:0]         done_perm,
    output logic                      fault_valid,
    output logic [P_VA_W-1:0]         fault_vaddr
);
    localparam int PFN_W = P_PA_W - PG_W;
    localparam int LVL_W = $clog2(LVLS);

    typedef struct packed {
        wk_state_e          st;
        logic [LVL_W-1:0]   lvl;
        logic [P_VA_W-1:0]  vaddr;
        logic [PFN_W-1:0]   base;
        logic               done;
        logic               fault;
        logic [PFN_W-1:0]   pfn;
        logic               huge;
        logic [P_PERM-1:0]  perm;
    } wk_t;

    wk_t r_d, r_q;

    logic [P_PA_W-1:0] rd_addr;
    logic              e_present, e_leaf, e_huge;
    logic [PFN_W-1:0]  e_next, e_pfn;
    logic [P_PERM-1:0] e_perm;

    pt_idx_sel #(
        .VA_W(P_VA_W), .PG_W(PG_W), .IDX_W(IDX_W), .LVLS(LVLS), .PFN_W(PFN_W)
    ) u_idx (
        .vaddr(r_q.vaddr), .lvl(r_q.lvl), .base(r_q.base), .addr(rd_addr)
    );

    pt_entry_dec #(
        .VA_W(P_VA_W), .PG_W(PG_W), .IDX_W(IDX_W), .LVLS(LVLS), .PFN_W(PFN_W),
        .ENT_W(P_ENT_W), .PERM_W(P_PERM), .PS_BIT(PS_BIT), .HUGE_LVL(HUGE_LVL)
    ) u_dec (
        .entry(mem_rsp_data), .lvl(r_q.lvl), .vaddr(r_q.vaddr),
        .present(e_present), .leaf(e_leaf), .huge(e_huge),
        .next_base(e_next), .leaf_pfn(e_pfn), .perm(e_perm)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        unique case (r_q.st)
            WK_IDLE: begin
                if (req_valid) begin
                    r_d.st    = WK_ISSUE;
                    r_d.lvl   = LVL_W'(LVLS - 1);
                    r_d.vaddr = req_vaddr;
                    r_d.base  = root_base[P_PA_W-1:PG_W];
                end
            end
            WK_ISSUE: begin
                r_d.st = WK_WAIT;
            end
            WK_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!e_present) begin
                        r_d.st    = WK_IDLE;
                        r_d.fault = 1'b1;
                    end else if (e_leaf) begin
                        r_d.st   = WK_IDLE;
                        r_d.done = 1'b1;
                        r_d.pfn  = e_pfn;
                        r_d.huge = e_huge;
                        r_d.perm = e_perm;
                    end else begin
                        r_d.st   = WK_ISSUE;
                        r_d.lvl  = r_q.lvl - 1'b1;
                        r_d.base = e_next;
                    end
                end
            end
            default: r_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: WK_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == WK_IDLE);
    assign mem_req_valid = (r_q.st == WK_ISSUE);
    assign mem_req_addr  = rd_addr;
    assign done_valid    = r_q.done;
    assign done_pfn      = r_q.pfn;
    assign done_huge     = r_q.huge;
    assign done_perm     = r_q.perm;
    assign fault_valid   = r_q.fault;
    assign fault_vaddr   = r_q.vaddr;

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);                        // R4
    AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);                            // R4
    AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));         // R3
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));                            // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);                              // R6
    AST_FAULT_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !mem_req_valid);                          // R5
    AST_IDLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> !(done_valid || fault_valid)); // R9
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [47:0] req_vaddr;
    logic [51:0] root_base;
    logic        mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done_valid;
    logic [39:0] done_pfn;
    logic        done_huge;
    logic [5:0]  done_perm;
    logic        fault_valid;
    logic [47:0] fault_vaddr;

    always #2.5 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_pfn(done_pfn), .done_huge(done_huge),
        .done_perm(done_perm), .fault_valid(fault_valid), .fault_vaddr(fault_vaddr)
    );

    // memory model
    logic [63:0] mem [logic [51:0]];
    logic [51:0] log_a [8];
    int          nlog = 0;
    int          lat  = 0;
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic [51:0] paddr;
    logic        rsp_v = 1'b0;
    logic [63:0] rsp_d = '0;
    logic        spur_v = 1'b0;
    logic [63:0] spur_d = '0;

    assign mem_rsp_valid = rsp_v | spur_v;
    assign mem_rsp_data  = spur_v ? spur_d : rsp_d;

    always @(posedge clk) begin
        rsp_v <= 1'b0;
        if (mem_req_valid) begin
            log_a[nlog % 8] <= mem_req_addr;
            nlog  <= nlog + 1;
            paddr <= mem_req_addr;
            pcnt  <= lat;
            pend  <= 1'b1;
        end else if (pend) begin
            if (pcnt == 0) begin
                rsp_v <= 1'b1;
                rsp_d <= mem.exists(paddr) ? mem[paddr] : 64'h0;
                pend  <= 1'b0;
            end else begin
                pcnt <= pcnt - 1;
            end
        end
    end

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ent(input logic [39:0] base, input logic [5:0] perm,
                                           input bit ps, input bit pr);
        logic [63:0] e;
        e = {1'b1, 11'h0, base, 12'h0};
        e[6:1] = perm;
        e[7]   = ps;
        e[0]   = pr;
        return e;
    endfunction

    task automatic walk(input int i);
        logic [8:0]  i4, i3, i2, i1;
        logic [11:0] off;
        logic [47:0] va;
        logic [39:0] rb, b3, b2, b1, fr, exp_pfn;
        logic [5:0]  perm;
        logic [51:0] ea [4];
        bit          pr [4];
        int          kind, fk, nexp, start, cyc;
        bit          huge, psx, busy_ok, got_done, got_fault;

        i4  = 9'((i * 37) % 512);
        i3  = 9'((i * 101 + 5) % 512);
        i2  = 9'((i * 211 + 9) % 512);
        i1  = 9'((i * 13 + 511) % 512);
        off = 12'((i * 97) % 4096);
        va  = {i4, i3, i2, i1, off};
        kind = i % 4;
        fk   = (i / 4) % 4;
        lat  = i % 4;
        rb   = 40'h00100 + 40'(i);
        b3   = 40'h01000 + 40'(i * 3);
        b2   = 40'h02000 + 40'(i * 5);
        b1   = 40'h03000 + 40'(i * 7);
        fr   = 40'hABC00 + 40'(i * 11);
        perm = 6'((i * 5) % 64);
        huge = (kind == 1);
        psx  = (kind == 3);
        for (int j = 0; j < 4; j++) pr[j] = !(kind == 2 && fk == j);

        mem.delete();
        ea[0] = {rb, i4, 3'b000};
        ea[1] = {b3, i3, 3'b000};
        ea[2] = {b2, i2, 3'b000};
        ea[3] = {b1, i1, 3'b000};
        mem[ea[0]] = mk_ent(b3, perm, psx, pr[0]);
        mem[ea[1]] = mk_ent(b2, perm, psx, pr[1]);
        mem[ea[2]] = mk_ent(huge ? fr : b1, perm, huge, pr[2]);
        if (!huge) mem[ea[3]] = mk_ent(fr, perm, psx, pr[3]);
        nexp    = (kind == 2) ? fk + 1 : (huge ? 3 : 4);
        exp_pfn = huge ? {fr[39:9], i1} : fr;

        if (i % 5 == 0) begin
            @(negedge clk);
            spur_v = 1'b1;
            spur_d = mk_ent(40'h77777, 6'h3F, 1'b0, 1'b1);
            @(negedge clk);
            spur_v = 1'b0;
            chk(!done_valid && !fault_valid, "R9", "idle stray response",
                {62'h0, done_valid, fault_valid}, 64'h0);
        end

        @(negedge clk);
        start     = nlog;
        req_valid = 1'b1;
        req_vaddr = va;
        root_base = {rb, 12'hA5A};
        @(negedge clk);
        if (i % 2 == 1) req_vaddr = ~va;
        else            req_valid = 1'b0;

        busy_ok = 1'b1;
        cyc     = 0;
        while (!(done_valid || fault_valid) && cyc < 100) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        got_done  = done_valid;
        got_fault = fault_valid;
        if (cyc >= 100) chk(1'b0, "R4", "walk timeout", 64'(cyc), 64'd100);
        chk(busy_ok, "R4", "ready low while busy", 64'(busy_ok), 64'd1);
        chk(nlog - start == nexp, "R5", "read count", 64'(nlog - start), 64'(nexp));
        if (nlog - start == nexp) begin
            chk(log_a[start % 8] == ea[0], "R2", "first read address",
                64'(log_a[start % 8]), 64'(ea[0]));
            for (int j = 1; j < nexp; j++)
                chk(log_a[(start + j) % 8] == ea[j], "R3", "later read address",
                    64'(log_a[(start + j) % 8]), 64'(ea[j]));
        end
        if (kind == 2) begin
            chk(got_fault && !got_done, "R5", "fault reported",
                {62'h0, got_done, got_fault}, 64'h1);
            chk(fault_vaddr == va, "R5", "fault address", 64'(fault_vaddr), 64'(va));
        end else begin
            chk(got_done && !got_fault, huge ? "R7" : "R6", "done reported",
                {62'h0, got_done, got_fault}, 64'h2);
            chk(done_pfn == exp_pfn, huge ? "R7" : (psx ? "R8" : "R6"), "frame number",
                64'(done_pfn), 64'(exp_pfn));
            chk(done_huge == huge, huge ? "R7" : "R8", "size flag",
                64'(done_huge), 64'(huge));
            chk(done_perm == perm, "R6", "permission bits", 64'(done_perm), 64'(perm));
        end
        @(negedge clk);
        chk(!done_valid && !fault_valid, "R6", "result is one pulse",
            {62'h0, done_valid, fault_valid}, 64'h0);
        chk(nlog - start == nexp, "R9", "no read after result",
            64'(nlog - start), 64'(nexp));
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_vaddr = '0;
        root_base = '0;
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_req_valid && !done_valid && !fault_valid, "R1",
            "state in reset", {60'h0, req_ready, mem_req_valid, done_valid, fault_valid},
            64'h8);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready && !mem_req_valid && !done_valid && !fault_valid, "R1",
            "state after reset", {60'h0, req_ready, mem_req_valid, done_valid, fault_valid},
            64'h8);
        for (int i = 0; i < 64; i++) walk(i);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule